// File: doc/BRIEF.md
# DMA Interrupt Vector Generator

This block decides whether a byte-programmed DMA controller should interrupt the CPU, and which vector byte to supply. It keeps three settings, each loaded through its own strobe: an interrupt-enable bit, an interrupt control byte and a base vector byte. Two event inputs report a pattern match and the end of a block.

When `req` is high at a clock edge, the block looks at the stored settings and the two event inputs. It picks the event with the higher priority that is enabled in the control byte. In the next cycle it drives a one-cycle pulse on `irq_valid` and updates `vec_out`. `vec_out` then stays unchanged until the next request.

The vector comes either straight from the base byte, or from the base byte with bits 2:1 replaced by an event code. Bit 5 of the control byte selects which of the two forms is used.

Top module: `dma_irq_vector`

## Requirements
- R1: After reset, the stored enable bit, control byte and base byte are all zero, `irq_valid` is 0 and `vec_out` is 0x00.
- R2: While the stored enable bit is 0, a request never produces an `irq_valid` pulse.
- R3: A match event qualifies only when bit 0 of the control byte is set. It gives event code 2, which sets vector bit 1.
- R4: An end-of-block event qualifies only when bit 1 of the control byte is set and no match event qualified in the same request. It gives event code 4, which sets vector bit 2.
- R5: When bit 5 of the control byte is set, the vector is `(base & 0xF9) + code`. When bit 5 is clear, the vector is the base byte unchanged.
- R6: When no event qualifies, the request produces no `irq_valid` pulse and `vec_out` becomes 0x00.
- R7: `irq_valid` is high for exactly the one cycle that follows a clock edge at which `req` was high and an event qualified.
- R8: `vec_out` changes only in the cycle after a request. A setting loaded in the same cycle as a request is used from the following request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ie_load | input | 1 | Load strobe for the enable bit |
| ie_in | input | 1 | New value of the enable bit |
| ctrl_load | input | 1 | Load strobe for the control byte |
| ctrl_in | input | 8 | New control byte |
| base_load | input | 1 | Load strobe for the base vector |
| base_in | input | 8 | New base vector |
| match_evt | input | 1 | Pattern-match event pending |
| endblk_evt | input | 1 | End-of-block event pending |
| req | input | 1 | Asks whether an interrupt should be raised |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| vec_out | output | 8 | Interrupt vector, held until the next request |

## Verification
The bench raises both events together with both enable bits of the control byte set. A design with the priority reversed would return code 4 where code 2 is expected. With bit 5 set, the base byte is 0xFF, so bits 2:1 must be cleared before the code goes in. A design that only ORs in the code would return 0xFF in every case. The bench also loads new settings in the same cycle as a request, which catches a design that uses the incoming value too early. Between requests it checks that `vec_out` holds its value, so a vector that follows the inputs freely, or a pulse that lasts more than one cycle, gets flagged.

// File: rtl/dma_irq_vector.sv
module dma_irq_vector #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ie_load,
  input  logic          ie_in,
  input  logic          ctrl_load,
  input  logic [7:0]    ctrl_in,
  input  logic          base_load,
  input  logic [VW-1:0] base_in,
  input  logic          match_evt,
  input  logic          endblk_evt,
  input  logic          req,
  output logic          irq_valid,
  output logic [VW-1:0] vec_out
);

  logic          ie_q;
  logic [7:0]    ctrl_q;
  logic [VW-1:0] base_q;

  logic          hit_match, hit_end, hit;
  logic [VW-1:0] code, vec_next;

  assign hit_match = ie_q & ctrl_q[0] & match_evt;
  assign hit_end   = ie_q & ctrl_q[1] & endblk_evt & ~hit_match;
  assign hit       = hit_match | hit_end;
  assign code      = hit_match ? VW'(2) : (hit_end ? VW'(4) : '0);
  assign vec_next  = !hit ? '0 :
                     ctrl_q[5] ? ((base_q & ~VW'(6)) + code) : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      ctrl_q    <= '0;
      base_q    <= '0;
      irq_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      if (ie_load)   ie_q   <= ie_in;
      if (ctrl_load) ctrl_q <= ctrl_in;
      if (base_load) base_q <= base_in;
      irq_valid <= req & hit;
      if (req) vec_out <= vec_next;
    end
  end

  a_r2_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ie_q) |=> !irq_valid);

  a_r7_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(req));

  a_r8_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && rst_n) |=> $stable(vec_out));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !match_evt && !endblk_evt) |=> (!irq_valid && vec_out == '0));

  a_r5_plain_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ctrl_q[5]) |=> (!irq_valid || vec_out == $past(base_q)));

  a_r3_match_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ctrl_q[5] && ctrl_q[0] && ie_q && match_evt) |=> (irq_valid && vec_out[2:1] == 2'b01));

endmodule

// File: tb/tb_dma_irq_vector.sv
module tb_dma_irq_vector;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ie_load = 0, ie_in = 0, ctrl_load = 0, base_load = 0;
  logic [7:0] ctrl_in = 0, base_in = 0;
  logic match_evt = 0, endblk_evt = 0, req = 0;
  logic irq_valid;
  logic [7:0] vec_out;

  int checks = 0, fails = 0;
  bit m_ie = 0;
  int m_ctrl = 0, m_base = 0, m_vec = 0;
  bit m_valid = 0;

  dma_irq_vector dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag);
    checks++;
    if (irq_valid !== m_valid || vec_out !== m_vec[7:0]) begin
      fails++;
      $display("FAIL %s: irq_valid=%0b vec=%02h expected irq_valid=%0b vec=%02h",
               tag, irq_valid, vec_out, m_valid, m_vec[7:0]);
    end
  endtask

  task automatic load(bit ie, int ctrl, int base);
    ie_load = 1; ie_in = ie; ctrl_load = 1; ctrl_in = ctrl[7:0];
    base_load = 1; base_in = base[7:0];
    @(negedge clk);
    ie_load = 0; ctrl_load = 0; base_load = 0;
    m_ie = ie; m_ctrl = ctrl; m_base = base; m_valid = 0;
    check("R8");
  endtask

  // reference: compute response to a request from model state
  task automatic request(bit m, bit e, string tag);
    int c;
    match_evt = m; endblk_evt = e; req = 1;
    c = 0;
    if (m_ie && m_ctrl[0] && m) c = 2;
    else if (m_ie && m_ctrl[1] && e) c = 4;
    @(negedge clk);
    req = 0; match_evt = 0; endblk_evt = 0;
    m_valid = (c != 0);
    if (c == 0) m_vec = 0;
    else if (m_ctrl[5]) m_vec = (m_base & 'hF9) + c;
    else m_vec = m_base;
    check(tag);
    @(negedge clk);
    m_valid = 0;
    check("R7");
    match_evt = 1; endblk_evt = 1;
    @(negedge clk);
    match_evt = 0; endblk_evt = 0;
    check("R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");
    request(1, 1, "R1");
    load(0, 'h23, 'h5A);
    request(1, 1, "R2");
    load(1, 'h21, 'hFF);
    request(1, 0, "R3");
    request(0, 1, "R3");
    load(1, 'h22, 'hFF);
    request(0, 1, "R4");
    request(1, 0, "R4");
    load(1, 'h23, 'hFF);
    request(1, 1, "R4");
    request(0, 1, "R4");
    load(1, 'h03, 'hA7);
    request(1, 1, "R5");
    load(1, 'h23, 'h3C);
    request(0, 1, "R5");
    request(0, 0, "R6");
    load(1, 'h00, 'h11);
    request(1, 1, "R6");
    // setting loaded with a request is not used until next request
    load(1, 'h21, 'h40);
    ctrl_load = 1; ctrl_in = 8'h01; base_load = 1; base_in = 8'h80;
    request(1, 0, "R8");
    ctrl_load = 0; base_load = 0;
    m_ctrl = 'h01; m_base = 'h80;
    request(1, 0, "R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule